// File: doc/BRIEF.md
# UART Register and Interrupt Core

This block is the host-facing heart of a byte-wide serial port. A processor reads and writes eight byte offsets. Behind them sit the configuration registers: interrupt enable, line control, modem control, scratch and the 16-bit baud divisor. Live status is gathered from the serial side into a line status byte and a modem status byte. The block merges four interrupt sources into one prioritised identification code and a single interrupt pin. The shift registers, the baud generator and any FIFOs sit outside the block.

Bytes cross the serial boundary as valid/ready streams. A received byte is offered on `rx_valid`/`rx_data`. It is taken on a cycle where `rx_ready` is also high. `rx_ready` is low while an unread byte is held, so the serial side must keep the byte and wait. A byte the host writes to the transmit holding register is offered on `tx_valid`/`tx_data`. It stays there until the shifter raises `tx_ready`, and that handshake marks the holding register empty again. Line errors, transmitter idle and the modem lines are plain level or strobe inputs.

The transmit-empty interrupt works on edges. It arms only when the condition "holding register empty and its enable set" rises. It is consumed by an identification read that reports it, or by a transmit write. A driver that enables transmit interrupts and then polls the identification register sees the transmit code once and then the idle code. It does not loop forever.

Top module: `uart_irq_core`

## Requirements
- R1: After reset, IER reads 0x00, LCR reads 0x00, IIR reads 0x01, LSR reads 0x60 (with `tx_idle` high) and `irq` is low.
- R2: While LCR bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte, and `divisor` = {high, low}. With bit 7 clear, those offsets reach the data and IER registers again.
- R3: IIR can report the transmit-empty code 0x02 only while IER bit 1 is 1 and LSR bit 5 (THRE) is 1.
- R4: The transmit-empty interrupt arms only on a rising edge of (THRE AND IER bit 1). Writes to other registers while that condition stays high do not re-arm it.
- R5: An IIR read that returns 0x02 clears the transmit-empty interrupt, so the next IIR read returns 0x01 when no other source is pending.
- R6: A write to offset 0 (bit 7 of LCR clear) clears THRE and the pending transmit-empty interrupt, and presents the byte on `tx_valid`/`tx_data`. A `tx_valid`/`tx_ready` handshake sets THRE again, and that counts as a new rising edge.
- R7: LSR = {0, THRE AND `tx_idle`, THRE, break, framing, parity, overrun, data ready}. `rx_err` bits 0..3 (overrun, parity, framing, break) latch into LSR bits 1..4, and reading LSR clears them.
- R8: IIR = 0x06 for a line error, 0x04 for receive data, 0x02 for transmit empty, and 0x00 for modem status, in that order of priority. A source counts only if its IER bit is set: bit 0 for receive, 1 for transmit, 2 for line, 3 for modem. 0x01 means nothing is pending.
- R9: `irq` is high exactly when IIR bit 0 is 0 and MCR bit 3 is 1.
- R10: Reading offset 0 (LCR bit 7 clear) returns the held receive byte and clears data ready. While a byte is held, `rx_ready` is low and offered bytes do not replace it.
- R11: MSR = {modem lines[3:0], change flags[3:0]}. Each change flag is set when its line changes, and reading MSR clears the flags.
- R12: IER reads back with bits 7:4 zero. Writes to offset 2 have no effect. Offset 7 is a read/write scratch byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read side effects take place at the clock edge |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as `bus_rd` |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive holding register free |
| rx_data | input | 8 | Received byte |
| rx_err | input | 4 | Line error strobes: overrun, parity, framing, break |
| tx_valid | output | 1 | Transmit holding register full |
| tx_ready | input | 1 | Shifter takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_idle | input | 1 | Shift register empty |
| modem_in | input | 4 | Modem status lines |
| irq | output | 1 | Interrupt request |
| divisor | output | 16 | Baud divisor |
| line_ctrl | output | 8 | Line control register |
| modem_ctrl | output | 5 | Modem control register |

## Verification
Register writes, receive and transmit handshakes, error strobes and modem-line changes take effect at the next clock edge. Reads of data and status registers therefore show them one cycle later. The transmit-empty interrupt passes through one more edge detector register, so it appears in IIR two edges after the write or handshake that raised its condition. `bus_rdata` and `irq` are combinational from state and are sampled in the same cycle as the read strobe, before that read's side effects land. Every bench read first waits one idle clock, so all results are due before sampling, including the slower transmit-empty edge. Sweeps then compare IIR, `irq`, IER readback and the divisor with values computed from the priority rule.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;
  localparam int SRC_N  = 4;
  localparam int IER_W  = 4;
  localparam int MCR_W  = 5;

  typedef enum logic [OFF_W-1:0] {
    OFF_DATA = 3'd0, OFF_IER = 3'd1, OFF_IIR = 3'd2, OFF_LCR = 3'd3,
    OFF_MCR  = 3'd4, OFF_LSR = 3'd5, OFF_MSR = 3'd6, OFF_SCR = 3'd7
  } reg_off_e;

  localparam logic [3:0] ID_NONE    = 4'h1;
  localparam logic [3:0] ID_LINE    = 4'h6;
  localparam logic [3:0] ID_RXDATA  = 4'h4;
  localparam logic [3:0] ID_TXEMPTY = 4'h2;
  localparam logic [3:0] ID_MODEM   = 4'h0;

  typedef struct packed {
    logic thr_wr;
    logic ier_wr;
    logic dll_wr;
    logic dlm_wr;
    logic lcr_wr;
    logic mcr_wr;
    logic scr_wr;
    logic rbr_rd;
    logic iir_rd;
    logic lsr_rd;
    logic msr_rd;
  } bus_op_t;

  // Source index order is the priority order: lowest index wins.
  function automatic logic [3:0] src_id(input int idx);
    case (idx)
      0:       return ID_LINE;
      1:       return ID_RXDATA;
      2:       return ID_TXEMPTY;
      default: return ID_MODEM;
    endcase
  endfunction
endpackage

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  bus_op_t               op,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [IER_W-1:0]      ier_q,
  output logic [BYTE_W-1:0]     lcr_q,
  output logic [MCR_W-1:0]      mcr_q,
  output logic [BYTE_W-1:0]     dll_q,
  output logic [BYTE_W-1:0]     dlm_q,
  output logic [BYTE_W-1:0]     scr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      dll_q <= '0;
      dlm_q <= '0;
      scr_q <= '0;
    end else begin
      if (op.ier_wr) ier_q <= wdata[IER_W-1:0];
      if (op.lcr_wr) lcr_q <= wdata;
      if (op.mcr_wr) mcr_q <= wdata[MCR_W-1:0];
      if (op.dll_wr) dll_q <= wdata;
      if (op.dlm_wr) dlm_q <= wdata;
      if (op.scr_wr) scr_q <= wdata;
    end
  end
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_irq_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               thr_wr,
  input  logic               rbr_rd,
  input  logic               lsr_rd,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic               rx_valid,
  output logic               rx_ready,
  input  logic [BYTE_W-1:0]  rx_data,
  input  logic [ERR_W-1:0]   rx_err,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [BYTE_W-1:0]  tx_data,
  input  logic               tx_idle,
  output logic [BYTE_W-1:0]  rbr_q,
  output logic [BYTE_W-1:0]  lsr,
  output logic               dr_q,
  output logic               err_any,
  output logic               thre_q
);
  localparam int PAD_W = BYTE_W - ERR_W - 3;

  logic [ERR_W-1:0] err_q;
  logic             rx_fire;
  logic             tx_fire;

  assign rx_ready = !dr_q;
  assign rx_fire  = rx_valid && rx_ready;
  assign tx_valid = !thre_q;
  assign tx_fire  = tx_valid && tx_ready;
  assign err_any  = |err_q;
  assign lsr      = {{PAD_W{1'b0}}, thre_q & tx_idle, thre_q, err_q, dr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q <= '0;
      dr_q  <= 1'b0;
    end else if (rx_fire) begin
      rbr_q <= rx_data;
      dr_q  <= 1'b1;
    end else if (rbr_rd) begin
      dr_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= rx_err | (lsr_rd ? '0 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_q  <= 1'b1;
      tx_data <= '0;
    end else if (thr_wr) begin
      thre_q  <= 1'b0;
      tx_data <= wdata;
    end else if (tx_fire) begin
      thre_q  <= 1'b1;
    end
  end

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && dr_q) |=> $stable(rbr_q));
  p_thr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (!thre_q && tx_valid));
  p_handshake_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !thr_wr) |=> thre_q);
endmodule

// File: rtl/uart_modem_status.sv
module uart_modem_status
  import uart_irq_pkg::*;
#(
  parameter int LINES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msr_rd,
  input  logic [LINES-1:0]   lines_in,
  output logic [2*LINES-1:0] msr,
  output logic               delta_any
);
  logic [LINES-1:0] line_q;
  logic [LINES-1:0] delta_q;
  logic             primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      line_q   <= lines_in;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_delta
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  delta_q[i] <= 1'b0;
      else if (primed_q && lines_in[i] != line_q[i]) delta_q[i] <= 1'b1;
      else if (msr_rd)                             delta_q[i] <= 1'b0;
    end
  end

  assign msr       = {line_q, delta_q};
  assign delta_any = |delta_q;

  p_change_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (primed_q && (lines_in != line_q)) |=> delta_any);
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IER_W-1:0]   ier,
  input  logic               line_lvl,
  input  logic               rx_lvl,
  input  logic               thre,
  input  logic               modem_lvl,
  input  logic               thr_wr,
  input  logic               iir_rd,
  input  logic               out2,
  output logic [BYTE_W-1:0]  iir,
  output logic               irq
);
  logic             tx_cond;
  logic             tx_cond_q;
  logic             tx_pend_q;
  logic [SRC_N-1:0] active;
  logic [3:0]       code;

  assign tx_cond = thre && ier[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_cond_q <= 1'b0;
    else        tx_cond_q <= tx_cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   tx_pend_q <= 1'b0;
    else if (!tx_cond)                            tx_pend_q <= 1'b0;
    else if (!tx_cond_q)                          tx_pend_q <= 1'b1;
    else if (thr_wr || (iir_rd && code == ID_TXEMPTY)) tx_pend_q <= 1'b0;
  end

  assign active[0] = line_lvl  && ier[2];
  assign active[1] = rx_lvl    && ier[0];
  assign active[2] = tx_pend_q && tx_cond;
  assign active[3] = modem_lvl && ier[3];

  always_comb begin
    code = ID_NONE;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (active[i]) code = src_id(i);
    end
  end

  assign iir = {{(BYTE_W-4){1'b0}}, code};
  assign irq = !code[0] && out2;

  p_thre_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iir[3:0] == ID_TXEMPTY) |-> (ier[1] && thre));
  p_thre_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pend_q) |-> ($past(tx_cond) && !$past(tx_cond, 2)));
  p_iir_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir[3:0] == ID_TXEMPTY) |=> !tx_pend_q);
  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (out2 && !iir[0]));
endmodule

// File: rtl/uart_irq_core.sv
module uart_irq_core
  import uart_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [OFF_W-1:0]     bus_addr,
  input  logic [BYTE_W-1:0]    bus_wdata,
  output logic [BYTE_W-1:0]    bus_rdata,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  input  logic [BYTE_W-1:0]    rx_data,
  input  logic [3:0]           rx_err,
  output logic                 tx_valid,
  input  logic                 tx_ready,
  output logic [BYTE_W-1:0]    tx_data,
  input  logic                 tx_idle,
  input  logic [3:0]           modem_in,
  output logic                 irq,
  output logic [2*BYTE_W-1:0]  divisor,
  output logic [BYTE_W-1:0]    line_ctrl,
  output logic [MCR_W-1:0]     modem_ctrl
);
  localparam int LINES = BYTE_W / 2;

  bus_op_t           op;
  reg_off_e          off;
  logic              dlab;
  logic [IER_W-1:0]  ier_q;
  logic [BYTE_W-1:0] dll_q, dlm_q, scr_q, rbr_q, lsr, msr, iir;
  logic              dr_q, err_any, thre_q, delta_any;

  assign off  = reg_off_e'(bus_addr);
  assign dlab = line_ctrl[BYTE_W-1];

  always_comb begin
    op        = '0;
    op.thr_wr = bus_wr && off == OFF_DATA && !dlab;
    op.dll_wr = bus_wr && off == OFF_DATA &&  dlab;
    op.ier_wr = bus_wr && off == OFF_IER  && !dlab;
    op.dlm_wr = bus_wr && off == OFF_IER  &&  dlab;
    op.lcr_wr = bus_wr && off == OFF_LCR;
    op.mcr_wr = bus_wr && off == OFF_MCR;
    op.scr_wr = bus_wr && off == OFF_SCR;
    op.rbr_rd = bus_rd && off == OFF_DATA && !dlab;
    op.iir_rd = bus_rd && off == OFF_IIR;
    op.lsr_rd = bus_rd && off == OFF_LSR;
    op.msr_rd = bus_rd && off == OFF_MSR;
  end

  uart_cfg_regs u_cfg (
    .clk, .rst_n, .op, .wdata(bus_wdata), .ier_q, .lcr_q(line_ctrl),
    .mcr_q(modem_ctrl), .dll_q, .dlm_q, .scr_q
  );

  uart_line_status #(.ERR_W(4)) u_line (
    .clk, .rst_n, .thr_wr(op.thr_wr), .rbr_rd(op.rbr_rd), .lsr_rd(op.lsr_rd),
    .wdata(bus_wdata), .rx_valid, .rx_ready, .rx_data, .rx_err, .tx_valid,
    .tx_ready, .tx_data, .tx_idle, .rbr_q, .lsr, .dr_q, .err_any, .thre_q
  );

  uart_modem_status #(.LINES(LINES)) u_modem (
    .clk, .rst_n, .msr_rd(op.msr_rd), .lines_in(modem_in), .msr, .delta_any
  );

  uart_irq_arbiter u_arb (
    .clk, .rst_n, .ier(ier_q), .line_lvl(err_any), .rx_lvl(dr_q),
    .thre(thre_q), .modem_lvl(delta_any), .thr_wr(op.thr_wr),
    .iir_rd(op.iir_rd), .out2(modem_ctrl[3]), .iir, .irq
  );

  assign divisor = {dlm_q, dll_q};

  always_comb begin
    case (off)
      OFF_DATA: bus_rdata = dlab ? dll_q : rbr_q;
      OFF_IER:  bus_rdata = dlab ? dlm_q : {{(BYTE_W-IER_W){1'b0}}, ier_q};
      OFF_IIR:  bus_rdata = iir;
      OFF_LCR:  bus_rdata = line_ctrl;
      OFF_MCR:  bus_rdata = {{(BYTE_W-MCR_W){1'b0}}, modem_ctrl};
      OFF_LSR:  bus_rdata = lsr;
      OFF_MSR:  bus_rdata = msr;
      default:  bus_rdata = scr_q;
    endcase
  end

  p_ier_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && off == OFF_IER && !dlab) |-> (bus_rdata[BYTE_W-1:IER_W] == '0));
endmodule

// File: tb/uart_irq_core_tb.sv
module uart_irq_core_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [2:0]  bus_addr = 0;
  logic [7:0]  bus_wdata = 0, bus_rdata;
  logic        rx_valid = 0, rx_ready;
  logic [7:0]  rx_data = 0;
  logic [3:0]  rx_err = 0;
  logic        tx_valid, tx_ready = 0;
  logic [7:0]  tx_data;
  logic        tx_idle = 1;
  logic [3:0]  modem_in = 0;
  logic        irq;
  logic [15:0] divisor;
  logic [7:0]  line_ctrl;
  logic [4:0]  modem_ctrl;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  uart_irq_core u_dut (.*);

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 50000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic irq_s);
    @(posedge clk); @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1; d = bus_rdata; irq_s = irq;
    @(posedge clk); @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d; logic q;
    rd(a, d, q);
    check(req, {8'h0, d}, {8'h0, exp});
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [7:0] exp_iir(input logic [3:0] ier, input logic ln,
                                         input logic rx, input logic tx, input logic ms);
    if (ier[2] && ln) return 8'h06;
    if (ier[0] && rx) return 8'h04;
    if (ier[1] && tx) return 8'h02;
    if (ier[3] && ms) return 8'h00;
    return 8'h01;
  endfunction

  initial begin
    logic [7:0] d; logic q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    // R1 reset state
    rd_chk("R1 ier", 1, 8'h00);
    rd_chk("R1 lcr", 3, 8'h00);
    rd_chk("R1 lsr", 5, 8'h60);
    rd(2, d, q);
    check("R1 iir", {8'h0, d}, 16'h0001);
    check("R1 irq", {15'h0, q}, 16'h0);

    // R2 divisor access, bring-up sequence of a polling driver
    wr(3, 8'h80); wr(0, 8'h0c); wr(1, 8'h00);
    check("R2 divisor", divisor, 16'h000c);
    rd_chk("R2 dll read", 0, 8'h0c);
    rd_chk("R2 dlm read", 1, 8'h00);
    wr(3, 8'h03);
    rd_chk("R2 ier restored", 1, 8'h00);
    wr(4, 8'h0b);
    rd_chk("R7 idle lsr", 5, 8'h60);
    rd_chk("R11 quiet msr", 6, 8'h00);
    rd_chk("R10 empty rbr", 0, 8'h00);
    wr(1, 8'h0f);
    rd(2, d, q);
    check("R5 first iir", {8'h0, d}, 16'h0002);
    check("R9 irq on", {15'h0, q}, 16'h1);
    rd(2, d, q);
    check("R5 second iir", {8'h0, d}, 16'h0001);
    check("R9 irq off", {15'h0, q}, 16'h0);
    wr(3, 8'h03); wr(7, 8'h5a);
    rd_chk("R4 no rearm", 2, 8'h01);
    rd_chk("R12 scratch", 7, 8'h5a);
    wr(2, 8'hff);
    rd_chk("R12 iir write ignored", 2, 8'h01);
    rd_chk("R12 ier unchanged", 1, 8'h0f);

    // R4 enable edge, R6 transmit write and handshake
    wr(1, 8'h0d); wr(1, 8'h0f);
    rd_chk("R4 enable edge", 2, 8'h02);
    wr(1, 8'h0d); wr(1, 8'h0f);
    tick();
    wr(0, 8'h55);
    rd_chk("R6 thr clears", 2, 8'h01);
    check("R6 tx_valid", {15'h0, tx_valid}, 16'h1);
    check("R6 tx_data", {8'h0, tx_data}, 16'h0055);
    rd_chk("R7 lsr busy", 5, 8'h00);
    tx_ready = 1; tick(); tx_ready = 0;
    check("R6 tx_valid drop", {15'h0, tx_valid}, 16'h0);
    rd_chk("R6 rearm", 2, 8'h02);
    rd_chk("R5 consumed", 2, 8'h01);
    tx_idle = 0;
    rd_chk("R7 temt needs idle", 5, 8'h20);
    tx_idle = 1;

    // R10 receive holding
    check("R10 ready", {15'h0, rx_ready}, 16'h1);
    rx_valid = 1; rx_data = 8'ha5; tick(); rx_data = 8'h11; tick(); rx_valid = 0;
    check("R10 not ready", {15'h0, rx_ready}, 16'h0);
    rd_chk("R8 rx code", 2, 8'h04);
    rd_chk("R10 byte kept", 0, 8'ha5);
    check("R10 ready again", {15'h0, rx_ready}, 16'h1);
    rd_chk("R10 cleared", 2, 8'h01);

    // R7 error latching
    rx_err = 4'b0101; tick(); rx_err = 0;
    rd_chk("R8 line code", 2, 8'h06);
    rd_chk("R7 errors", 5, 8'h6a);
    rd_chk("R7 errors cleared", 5, 8'h60);
    rd_chk("R7 iir idle", 2, 8'h01);

    // R11 modem changes
    modem_in = 4'b1010; tick();
    rd_chk("R8 modem code", 2, 8'h00);
    rd_chk("R11 msr", 6, 8'haa);
    rd_chk("R11 msr cleared", 6, 8'ha0);
    rd_chk("R11 iir idle", 2, 8'h01);

    // R12 IER readback sweep
    for (int v = 0; v < 256; v++) begin
      wr(1, v[7:0]);
      rd_chk("R12 ier sweep", 1, v[7:0] & 8'h0f);
    end

    // R2 divisor sweep
    wr(3, 8'h80);
    for (int k = 0; k < 16; k++) begin
      logic [7:0] lo, hi;
      lo = k[7:0] * 8'd17; hi = ~lo ^ {k[3:0], 4'h0};
      wr(0, lo); wr(1, hi);
      check("R2 divisor sweep", divisor, {hi, lo});
    end
    wr(3, 8'h03);

    // R8/R9 priority sweep with every source active
    wr(1, 8'h00);
    rx_valid = 1; rx_data = 8'h3c; tick(); rx_valid = 0;
    rx_err = 4'b1000; tick(); rx_err = 0;
    modem_in = 4'b0000; tick();
    for (int m = 0; m < 2; m++) begin
      wr(4, m[0] ? 8'h08 : 8'h00);
      for (int v = 0; v < 16; v++) begin
        logic [7:0] e;
        e = exp_iir(v[3:0], 1'b1, 1'b1, 1'b1, 1'b1);
        wr(1, 8'h00); wr(1, v[7:0]);
        rd(2, d, q);
        check("R8 priority sweep", {8'h0, d}, {8'h0, e});
        check("R9 irq sweep", {15'h0, q}, {15'h0, (e != 8'h01) && m[0]});
      end
    end

    // R8 descent through the sources, IER still 0x0f
    rd_chk("R8 top line", 2, 8'h06);
    rd_chk("R7 break bit", 5, 8'h71);
    rd_chk("R8 then rx", 2, 8'h04);
    rd_chk("R10 rx byte", 0, 8'h3c);
    rd_chk("R8 then tx", 2, 8'h02);
    rd_chk("R8 then modem", 2, 8'h00);
    rd_chk("R11 deltas", 6, 8'h0a);
    rd(2, d, q);
    check("R8 none", {8'h0, d}, 16'h0001);
    check("R9 irq none", {15'h0, q}, 16'h0);

    summary();
  end
endmodule